// File: doc/BRIEF.md
# Paired-Pattern Gate Evaluator with Stuck-At Masking

This block evaluates one cell of a small logic library for two test patterns at the same time. Each gate input arrives as a 2-bit pair, one bit for each pattern. A single truth-table lookup returns the gate output for both patterns at once. The table is built inside the block when it is elaborated. A per-transaction fault mask can then pass the looked-up pair unchanged, force it to 0 or force it to 1. This models a stuck-at fault on the gate output.

When detect mode is enabled, the masked pair is compared with a supplied fault-free pair, and a single detect bit reports any difference. A fault-simulation engine feeds the block one gate evaluation per accepted transaction.

Both sides use valid/ready handshakes. A transaction is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid` one cycle later. The result stays frozen while the consumer holds `out_ready` low. The block accepts new input only when its output slot is empty or is being drained in the same cycle. A held-off producer must keep its inputs until it sees `in_ready`.

Top module: `paired_gate_eval`

## Requirements
- R1: `in_sel` picks the cell as follows:
  - 0 is an inverter.
  - 1 to 4 are 2-input AND, OR, NAND and NOR, in that order.
  - 5 to 8 are the 3-input forms, in the same order.
  - 9 to 12 are the 4-input forms, in the same order.
  - Output bit p is the cell function applied to bit p of each used input.
- R2: Input k is `in_pairs[2k+1:2k]`, where bit 0 belongs to pattern 0 and bit 1 to pattern 1. The inverter uses only input 0. An n-input cell uses inputs 0 to n-1. Pairs at or above the cell's input count have no effect on the result.
- R3: The reserved codes 13 to 15 give a looked-up pair of 00 before masking.
- R4: The result is (looked-up pair AND `in_m0`) OR `in_m1`, bit by bit. With m0=11 and m1=00 the looked-up pair passes unchanged.
- R5: m1=11 forces a result of 11 whatever m0 is. m0=00 with m1=00 forces a result of 00.
- R6: With `in_detect_en` high, `out_detect` is 1 exactly when the result differs from `in_good` in either bit. With `in_detect_en` low, `out_detect` is 0.
- R7: An accepted transaction raises `out_valid` at the next rising edge. `out_valid` falls after a handshake on the output when no new transaction is accepted.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result` and `out_detect` stay constant.
- R9: During and after reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can accept a transaction |
| in_sel | input | 4 | Cell code |
| in_pairs | input | 8 | Four 2-bit input pairs, input k at bits 2k+1:2k |
| in_m0 | input | 2 | AND mask |
| in_m1 | input | 2 | OR mask |
| in_good | input | 2 | Fault-free pair for comparison |
| in_detect_en | input | 1 | Enables the detect comparison |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 2 | Masked output pair, bit p for pattern p |
| out_detect | output | 1 | Result differs from the fault-free pair |

## Verification
The bench drives every cell code with inputs whose two pattern bits differ. A table laid out at the wrong offset, or with the two patterns swapped, would then return the wrong bit in one position. Junk is placed on the pairs above a cell's input count; an address that does not drop unused inputs would read another cell's entries. Reserved codes, mixed per-bit masks and the stuck-at-1 override are aimed at a mask applied in the wrong order. A stalled output with a changing input checks that a held result is not overwritten and that nothing is lost or duplicated once the stall clears.

// File: rtl/pge_pkg.sv
package pge_pkg;
  localparam int NUM_IN   = 4;
  localparam int PAT_W    = 2;
  localparam int SEL_W    = 4;
  localparam int NUM_KIND = 4;  // AND, OR, NAND, NOR
  localparam int OFS2     = 4;                      // after the inverter
  localparam int OFS3     = OFS2 + NUM_KIND * 16;
  localparam int OFS4     = OFS3 + NUM_KIND * 64;
  localparam int DEPTH    = OFS4 + NUM_KIND * 256;  // 1348
  localparam int ADDR_W   = $clog2(DEPTH + 1);
  localparam int LAST_SEL = 3 * NUM_KIND;           // 12

  typedef logic [PAT_W-1:0] pair_t;

  function automatic int sel_arity(input logic [SEL_W-1:0] s);
    if (s == 0) return 1;
    if (int'(s) > LAST_SEL) return 0;
    return (int'(s) - 1) / NUM_KIND + 2;
  endfunction

  function automatic int sel_offset(input logic [SEL_W-1:0] s);
    int k;
    if (s == 0) return 0;
    if (int'(s) > LAST_SEL) return DEPTH;
    k = (int'(s) - 1) % NUM_KIND;
    case ((int'(s) - 1) / NUM_KIND)
      0:       return OFS2 + k * 16;
      1:       return OFS3 + k * 64;
      default: return OFS4 + k * 256;
    endcase
  endfunction

  // Content of one table word, derived from the cell functions.
  function automatic pair_t lib_word(input logic [ADDR_W-1:0] a);
    int ai, n, kind, loc;
    pair_t w;
    ai = int'(a);
    w  = '0;
    if (ai < OFS2) begin
      n = 1; kind = -1; loc = ai;
    end else if (ai < OFS3) begin
      n = 2; kind = (ai - OFS2) / 16;  loc = (ai - OFS2) % 16;
    end else if (ai < OFS4) begin
      n = 3; kind = (ai - OFS3) / 64;  loc = (ai - OFS3) % 64;
    end else if (ai < DEPTH) begin
      n = 4; kind = (ai - OFS4) / 256; loc = (ai - OFS4) % 256;
    end else begin
      return '0;
    end
    for (int p = 0; p < PAT_W; p++) begin
      logic all1, any1;
      all1 = 1'b1;
      any1 = 1'b0;
      for (int i = 0; i < n; i++) begin
        logic b;
        b = 1'b0;
        if (((loc >> (2 * i + p)) & 1) != 0) b = 1'b1;
        all1 = all1 & b;
        any1 = any1 | b;
      end
      case (kind)
        -1:      w[p] = ~any1;
        0:       w[p] = all1;
        1:       w[p] = any1;
        2:       w[p] = ~all1;
        default: w[p] = ~any1;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/gate_addr_gen.sv
module gate_addr_gen
  import pge_pkg::*;
#(
  parameter int N_IN = NUM_IN,
  parameter int S_W  = SEL_W,
  parameter int A_W  = ADDR_W
) (
  input  logic [S_W-1:0]    sel,
  input  logic [2*N_IN-1:0] pairs,
  output logic [A_W-1:0]    addr
);
  logic [A_W-1:0] term [N_IN];
  int arity;

  always_comb arity = sel_arity(sel);

  // Pairs beyond the cell's input count are dropped so they cannot
  // index into a neighbouring cell's entries.
  for (genvar i = 0; i < N_IN; i++) begin : g_term
    always_comb begin
      term[i] = '0;
      if (i < arity) term[i] = A_W'(pairs[2*i +: 2]) << (2 * i);
    end
  end

  always_comb begin
    addr = A_W'(sel_offset(sel));
    for (int i = 0; i < N_IN; i++) addr = addr + term[i];
  end
endmodule

// File: rtl/truth_rom.sv
module truth_rom
  import pge_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int W   = PAT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [A_W-1:0] addr,
  output logic [W-1:0]   q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= W'(lib_word(ADDR_W'(addr)));
  end
endmodule

// File: rtl/fault_mask_cmp.sv
module fault_mask_cmp #(
  parameter int W = 2
) (
  input  logic [W-1:0] raw,
  input  logic [W-1:0] m0,
  input  logic [W-1:0] m1,
  input  logic [W-1:0] good,
  input  logic         det_en,
  output logic [W-1:0] result,
  output logic         detect
);
  always_comb begin
    result = (raw & m0) | m1;
    detect = det_en && (result != good);
  end
endmodule

// File: rtl/paired_gate_eval.sv
module paired_gate_eval
  import pge_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SEL_W-1:0]    in_sel,
  input  logic [2*NUM_IN-1:0] in_pairs,
  input  logic [PAT_W-1:0]    in_m0,
  input  logic [PAT_W-1:0]    in_m1,
  input  logic [PAT_W-1:0]    in_good,
  input  logic                in_detect_en,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PAT_W-1:0]    out_result,
  output logic                out_detect
);
  logic              take;
  logic [ADDR_W-1:0] addr;
  logic [PAT_W-1:0]  raw_q, m0_q, m1_q, good_q;
  logic              den_q, valid_q;

  assign in_ready  = !valid_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = valid_q;

  gate_addr_gen #(.N_IN(NUM_IN), .S_W(SEL_W), .A_W(ADDR_W)) i_addr (
    .sel(in_sel), .pairs(in_pairs), .addr(addr)
  );

  truth_rom #(.A_W(ADDR_W), .W(PAT_W)) i_rom (
    .clk(clk), .rst_n(rst_n), .en(take), .addr(addr), .q(raw_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      m0_q    <= '0;
      m1_q    <= '0;
      good_q  <= '0;
      den_q   <= 1'b0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        m0_q    <= in_m0;
        m1_q    <= in_m1;
        good_q  <= in_good;
        den_q   <= in_detect_en;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  fault_mask_cmp #(.W(PAT_W)) i_mask (
    .raw(raw_q), .m0(m0_q), .m1(m1_q), .good(good_q), .det_en(den_q),
    .result(out_result), .detect(out_detect)
  );

  // R7: an accepted transaction is presented next cycle
  p_accept_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  // R8: a stalled result is held
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_detect)));
  // R8: ready whenever the slot is empty
  p_ready_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R5: stuck-at-1 override
  p_sa1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_m1 == 2'b11) |=> out_result == 2'b11);
  // R5: stuck-at-0
  p_sa0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_m0 == 2'b00 && in_m1 == 2'b00) |=> out_result == 2'b00);
  // R6: detect off when not enabled
  p_det_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_detect_en) |=> !out_detect);
endmodule

// File: tb/test_paired_gate_eval.sv
module test_paired_gate_eval;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_detect_en, out_valid, out_ready, out_detect;
  logic [3:0] in_sel;
  logic [7:0] in_pairs;
  logic [1:0] in_m0, in_m1, in_good, out_result;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  paired_gate_eval i_paired_gate_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_pairs(in_pairs), .in_m0(in_m0), .in_m1(in_m1),
    .in_good(in_good), .in_detect_en(in_detect_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_detect(out_detect)
  );

  function automatic logic [1:0] cell_model(input logic [3:0] s, input logic [7:0] pr);
    logic [1:0] r;
    int n;
    r = 2'b00;
    case (s)
      0:          n = 1;
      1, 2, 3, 4: n = 2;
      5, 6, 7, 8: n = 3;
      9, 10, 11, 12: n = 4;
      default:    n = 0;
    endcase
    for (int p = 0; p < 2; p++) begin
      logic a, o;
      a = 1'b1; o = 1'b0;
      for (int i = 0; i < n; i++) begin
        a = a & pr[2*i+p];
        o = o | pr[2*i+p];
      end
      if (s == 0)            r[p] = ~pr[p];
      else if (n == 0)       r[p] = 1'b0;
      else if (s % 4 == 1)   r[p] = a;
      else if (s % 4 == 2)   r[p] = o;
      else if (s % 4 == 3)   r[p] = ~a;
      else                   r[p] = ~o;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] s, input logic [7:0] pr, input logic [1:0] m0,
                       input logic [1:0] m1, input logic [1:0] g, input logic de);
    in_sel = s; in_pairs = pr; in_m0 = m0; in_m1 = m1; in_good = g; in_detect_en = de;
    in_valid = 1'b1;
  endtask

  // One transaction with the consumer always ready, checked one cycle later.
  task automatic send(input string req, input logic [3:0] s, input logic [7:0] pr,
                      input logic [1:0] m0, input logic [1:0] m1, input logic [1:0] g,
                      input logic de);
    logic [1:0] er;
    @(negedge clk);
    drive(s, pr, m0, m1, g, de);
    @(negedge clk);
    in_valid = 1'b0;
    er = (cell_model(s, pr) & m0) | m1;
    check({req, " R7 valid"}, {1'b0, out_valid}, 2'b01);
    check({req, " result"}, out_result, er);
    check({req, " R6 detect"}, {1'b0, out_detect}, {1'b0, de && (er != g)});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    drive(4'd0, 8'h00, 2'b11, 2'b00, 2'b00, 1'b0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {1'b0, out_valid}, 2'b00);
    check("R8 ready empty", {1'b0, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {1'b0, out_valid}, 2'b00);

    // R1: NAND3, inputs 0 and 1 high, input 2 low in both patterns -> 11
    send("R1 nand3 110", 4'd7, 8'b00_00_11_11, 2'b11, 2'b00, 2'b00, 1'b0);
    // R1: NAND3 mixed patterns: pattern0 all ones -> 0, pattern1 0,1,1 -> 1
    send("R1 nand3 mixed", 4'd7, 8'b00_11_11_01, 2'b11, 2'b00, 2'b00, 1'b0);
    // R1/R2: every cell with junk on the unused pairs
    for (int s = 0; s <= 12; s++) begin
      send("R1 R2 sweep", 4'(s), 8'b10_01_11_01, 2'b11, 2'b00, 2'b00, 1'b0);
      send("R2 unused", 4'(s), 8'b11_10_01_10, 2'b11, 2'b00, 2'b00, 1'b0);
    end
    send("R2 inv ignores", 4'd0, 8'b11_11_11_01, 2'b11, 2'b00, 2'b00, 1'b0);
    // R3: reserved codes
    send("R3 reserved 13", 4'd13, 8'hFF, 2'b11, 2'b00, 2'b00, 1'b0);
    send("R3 reserved 15", 4'd15, 8'h5A, 2'b11, 2'b00, 2'b11, 1'b1);
    // R4: mixed per-bit masks
    send("R4 mixed mask", 4'd2, 8'b00_00_01_10, 2'b01, 2'b00, 2'b00, 1'b1);
    send("R4 mixed or", 4'd3, 8'b00_00_11_11, 2'b11, 2'b10, 2'b10, 1'b1);
    // R5: stuck-at forcing
    send("R5 sa1", 4'd1, 8'h00, 2'b00, 2'b11, 2'b00, 1'b1);
    send("R5 sa0", 4'd4, 8'h00, 2'b00, 2'b00, 2'b11, 1'b1);
    // R6: detect off and on
    send("R6 detect off", 4'd4, 8'h00, 2'b00, 2'b00, 2'b11, 1'b0);
    send("R6 detect equal", 4'd1, 8'b00_00_11_11, 2'b11, 2'b00, 2'b11, 1'b1);

    // R7: valid drops after drain
    @(negedge clk);
    check("R7 valid drops", {1'b0, out_valid}, 2'b00);

    // R8: back-pressure
    out_ready = 1'b0;
    drive(4'd5, 8'b00_00_11_11, 2'b11, 2'b00, 2'b00, 1'b1);  // AND2? no: AND3 -> 00
    @(negedge clk);
    check("R8 held valid", {1'b0, out_valid}, 2'b01);
    check("R8 ready low", {1'b0, in_ready}, 2'b00);
    check("R8 first result", out_result, 2'b00);
    drive(4'd6, 8'b00_00_00_11, 2'b11, 2'b00, 2'b00, 1'b1);  // OR3 -> 11
    @(negedge clk);
    check("R8 stable result", out_result, 2'b00);
    check("R8 stable detect", {1'b0, out_detect}, 2'b00);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second result", out_result, 2'b11);
    check("R8 second detect", {1'b0, out_detect}, 2'b01);
    @(negedge clk);
    check("R8 no duplicate", {1'b0, out_valid}, 2'b00);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      send("R1 R4 R6 random", 4'($urandom_range(0, 15)), 8'($urandom),
           2'($urandom), ($urandom_range(0, 3) == 0) ? 2'b11 : 2'($urandom & 1),
           2'($urandom), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule